// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This controller sits between the host strobes and a byte-wide static memory. Its job is to keep the stored data intact while the supply collapses and comes back. Two comparator flags arrive already debounced and synchronous to the clock:

- one says the supply is under the deselect threshold;
- the other says it is under the level where the memory must run from its backup cell.

From these flags the sequencer moves through four states: normal, protected, battery and recovering. It drives the protection outputs, the battery selection and a gated write strobe for the array.

Protection does not engage on the first cycle the deselect flag appears. The flag must stay high for a configurable number of cycles, which models the worst-case late engagement allowed for a fast supply fall. Release is slower still. The supply must stay above the deselect threshold for a full programmable recovery interval, counted in clock cycles, before host strobes are honoured again. If a write is under way at the moment protection engages, it is cut off at once. A flag then records that the addressed byte may be damaged.

Top module: `pfws_top`

## Requirements
- R1: While reset (rstN low) is asserted and in the first cycle after its release, writeProtect, outputHiZ, inputIgnore, batterySel, memWriteEn and tornFlag are all 0.
- R2: While not protected, memWriteEn is 1 exactly when hostCeN and hostWeN are both 0 (active-low strobes), with no cycle of delay.
- R3: With belowDeselect high on ENGAGE_CYC consecutive rising edges, writeProtect, outputHiZ and inputIgnore become 1 after the last of those edges. A shorter high pulse leaves them at 0.
- R4: Whenever writeProtect is 1, memWriteEn is 0 whatever the strobes do. A write active at the engaging edge is cut in the same cycle that protection appears.
- R5: When belowSwitch is 1 at a rising edge, batterySel is 1 after that edge, from any state, and protection is also held. When belowSwitch is 0 at an edge, batterySel is 0 after it and protection remains.
- R6: After belowDeselect is first seen low in the protected state, protection stays for RECOVER_CYC further edges. It is released after edge RECOVER_CYC+1 counted from that sample.
- R7: belowDeselect seen high during recovery returns the block to the protected state. The next recovery then runs the full RECOVER_CYC interval again.
- R8: At the edge where protection engages from normal operation, tornFlag takes the value 1 if hostCeN and hostWeN are both 0, else 0. At every other edge it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| belowDeselect | input | 1 | Supply below the deselect threshold |
| belowSwitch | input | 1 | Supply below the battery switchover threshold |
| hostCeN | input | 1 | Host chip enable, active low |
| hostWeN | input | 1 | Host write enable, active low |
| writeProtect | output | 1 | Array writes blocked |
| outputHiZ | output | 1 | Data outputs forced to high impedance |
| inputIgnore | output | 1 | Host inputs treated as don't-care |
| batterySel | output | 1 | Array powered from the backup cell |
| memWriteEn | output | 1 | Gated write strobe to the array |
| tornFlag | output | 1 | A write was cut off at the last protection entry |

## Verification
Each result has its own due cycle:

- memWriteEn follows the strobes in the same cycle.
- batterySel answers one edge after belowSwitch is sampled.
- Protection appears ENGAGE_CYC edges after belowDeselect is first sampled high.
- Release comes RECOVER_CYC+1 edges after belowDeselect is first sampled low.

The driver stamps every expected item with the exact edge count at which it falls due, derived from these rules. The monitor samples one nanosecond after each rising edge and compares only items whose stamp matches the current count. The checks just before and just after each boundary therefore catch an interval that is off by one in either direction.

// File: rtl/pfws_pkg.sv
package pfws_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_PROTECT = 2'd1,
    ST_BATTERY = 2'd2,
    ST_RECOVER = 2'd3
  } pwrState_t;

  typedef struct packed {
    logic engInc;
    logic engClr;
    logic recInc;
    logic recClr;
    logic captureTorn;
  } seqStrobe_t;

endpackage

// File: rtl/pfws_ctrl.sv
module pfws_ctrl
  import pfws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       belowDeselect,
  input  logic       belowSwitch,
  input  logic       engDone,
  input  logic       recDone,
  output pwrState_t  state,
  output seqStrobe_t strobe
);

  pwrState_t nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_NORMAL: begin
        if (belowSwitch) begin
          nextState          = ST_BATTERY;
          strobe.captureTorn = 1'b1;
          strobe.engClr      = 1'b1;
        end else if (belowDeselect) begin
          if (engDone) begin
            nextState          = ST_PROTECT;
            strobe.captureTorn = 1'b1;
            strobe.engClr      = 1'b1;
          end else begin
            strobe.engInc = 1'b1;
          end
        end else begin
          strobe.engClr = 1'b1;
        end
      end
      ST_PROTECT: begin
        if (belowSwitch) begin
          nextState = ST_BATTERY;
        end else if (!belowDeselect) begin
          nextState     = ST_RECOVER;
          strobe.recClr = 1'b1;
        end
      end
      ST_BATTERY: begin
        if (!belowSwitch) nextState = ST_PROTECT;
      end
      ST_RECOVER: begin
        if (belowSwitch) begin
          nextState = ST_BATTERY;
        end else if (belowDeselect) begin
          nextState = ST_PROTECT;
        end else if (recDone) begin
          nextState = ST_NORMAL;
        end else begin
          strobe.recInc = 1'b1;
        end
      end
      default: nextState = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_NORMAL;
    else       state <= nextState;
  end

endmodule

// File: rtl/pfws_datapath.sv
module pfws_datapath
  import pfws_pkg::*;
#(
  parameter int ENGAGE_CYC  = 3,
  parameter int RECOVER_CYC = 4000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  pwrState_t  state,
  input  seqStrobe_t strobe,
  input  logic       hostCeN,
  input  logic       hostWeN,
  output logic       engDone,
  output logic       recDone,
  output logic       writeProtect,
  output logic       outputHiZ,
  output logic       inputIgnore,
  output logic       batterySel,
  output logic       memWriteEn,
  output logic       tornFlag
);

  localparam int ENG_W = (ENGAGE_CYC > 1) ? $clog2(ENGAGE_CYC) : 1;
  localparam int REC_W = (RECOVER_CYC > 1) ? $clog2(RECOVER_CYC) : 1;
  localparam logic [ENG_W-1:0] ENG_LAST = ENG_W'(ENGAGE_CYC - 1);
  localparam logic [REC_W-1:0] REC_LAST = REC_W'(RECOVER_CYC - 1);

  logic [ENG_W-1:0] engCnt;
  logic [REC_W-1:0] recCnt;
  logic             protActive;
  logic             hostWrite;

  assign hostWrite  = !hostCeN && !hostWeN;
  assign protActive = (state != ST_NORMAL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              engCnt <= '0;
    else if (strobe.engClr) engCnt <= '0;
    else if (strobe.engInc) engCnt <= engCnt + ENG_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              recCnt <= '0;
    else if (strobe.recClr) recCnt <= '0;
    else if (strobe.recInc) recCnt <= recCnt + REC_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   tornFlag <= 1'b0;
    else if (strobe.captureTorn) tornFlag <= hostWrite;
  end

  assign engDone      = (engCnt == ENG_LAST);
  assign recDone      = (recCnt == REC_LAST);
  assign writeProtect = protActive;
  assign outputHiZ    = protActive;
  assign inputIgnore  = protActive;
  assign batterySel   = (state == ST_BATTERY);
  assign memWriteEn   = !protActive && hostWrite;

endmodule

// File: rtl/pfws_top.sv
module pfws_top
  import pfws_pkg::*;
#(
  parameter int ENGAGE_CYC  = 3,
  parameter int RECOVER_CYC = 4000000
) (
  input  logic clk,
  input  logic rstN,
  input  logic belowDeselect,
  input  logic belowSwitch,
  input  logic hostCeN,
  input  logic hostWeN,
  output logic writeProtect,
  output logic outputHiZ,
  output logic inputIgnore,
  output logic batterySel,
  output logic memWriteEn,
  output logic tornFlag
);

  pwrState_t  state;
  seqStrobe_t strobe;
  logic       engDone;
  logic       recDone;

  pfws_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .belowDeselect (belowDeselect),
    .belowSwitch   (belowSwitch),
    .engDone       (engDone),
    .recDone       (recDone),
    .state         (state),
    .strobe        (strobe)
  );

  pfws_datapath #(
    .ENGAGE_CYC  (ENGAGE_CYC),
    .RECOVER_CYC (RECOVER_CYC)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .state        (state),
    .strobe       (strobe),
    .hostCeN      (hostCeN),
    .hostWeN      (hostWeN),
    .engDone      (engDone),
    .recDone      (recDone),
    .writeProtect (writeProtect),
    .outputHiZ    (outputHiZ),
    .inputIgnore  (inputIgnore),
    .batterySel   (batterySel),
    .memWriteEn   (memWriteEn),
    .tornFlag     (tornFlag)
  );

endmodule

// File: rtl/pfws_checker.sv
module pfws_checker #(
  parameter int RECOVER_CYC = 4000000
) (
  input logic clk,
  input logic rstN,
  input logic belowDeselect,
  input logic belowSwitch,
  input logic hostCeN,
  input logic hostWeN,
  input logic writeProtect,
  input logic outputHiZ,
  input logic inputIgnore,
  input logic batterySel,
  input logic memWriteEn,
  input logic tornFlag
);

  localparam int WIN_W = $clog2(RECOVER_CYC + 2) + 1;

  logic [WIN_W-1:0] quietCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      quietCnt <= '0;
    else if (writeProtect && !belowDeselect && !belowSwitch) begin
      if (quietCnt != '1) quietCnt <= quietCnt + WIN_W'(1);
    end else
      quietCnt <= '0;
  end

  // R4
  a_r4_no_write_when_protected: assert property (@(posedge clk) disable iff (!rstN)
    writeProtect |-> !memWriteEn);

  // R5
  a_r5_battery_follows_switch: assert property (@(posedge clk) disable iff (!rstN)
    belowSwitch |=> batterySel);

  // R5
  a_r5_battery_keeps_protect: assert property (@(posedge clk) disable iff (!rstN)
    batterySel |-> (writeProtect && outputHiZ && inputIgnore));

  // R6
  a_r6_recovery_window: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeProtect) |-> (quietCnt >= WIN_W'(RECOVER_CYC)));

  // R8
  a_r8_torn_capture: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(writeProtect) && $past(!hostCeN && !hostWeN)) |-> tornFlag);

  // R8
  a_r8_torn_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(writeProtect) |-> $stable(tornFlag));

endmodule

bind pfws_top pfws_checker #(.RECOVER_CYC(RECOVER_CYC)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .belowDeselect (belowDeselect),
  .belowSwitch   (belowSwitch),
  .hostCeN       (hostCeN),
  .hostWeN       (hostWeN),
  .writeProtect  (writeProtect),
  .outputHiZ     (outputHiZ),
  .inputIgnore   (inputIgnore),
  .batterySel    (batterySel),
  .memWriteEn    (memWriteEn),
  .tornFlag      (tornFlag)
);

// File: tb/sim_pfws_top.sv
`timescale 1ns/1ps
module sim_pfws_top;

  localparam int ENG = 3;
  localparam int REC = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic belowDeselect = 1'b0;
  logic belowSwitch = 1'b0;
  logic hostCeN = 1'b1;
  logic hostWeN = 1'b1;
  logic writeProtect, outputHiZ, inputIgnore, batterySel, memWriteEn, tornFlag;

  always #2 clk = ~clk;

  pfws_top #(.ENGAGE_CYC(ENG), .RECOVER_CYC(REC)) u0 (
    .clk(clk), .rstN(rstN), .belowDeselect(belowDeselect), .belowSwitch(belowSwitch),
    .hostCeN(hostCeN), .hostWeN(hostWeN), .writeProtect(writeProtect),
    .outputHiZ(outputHiZ), .inputIgnore(inputIgnore), .batterySel(batterySel),
    .memWriteEn(memWriteEn), .tornFlag(tornFlag)
  );

  typedef struct {
    int    due;
    logic  wp;
    logic  bat;
    logic  wen;
    logic  torn;
    string tag;
  } expItem_t;

  expItem_t q[$];
  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  task automatic chk(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, name, act, exp);
    end
  endtask

  task automatic expectIn(int n, logic wp, logic bat, logic wen, logic torn, string tag);
    q.push_back('{cyc + n, wp, bat, wen, torn, tag});
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN) cyc++;
      while (q.size() > 0 && q[0].due == cyc) begin
        expItem_t it;
        it = q.pop_front();
        chk(it.tag, "writeProtect", writeProtect, it.wp);
        chk(it.tag, "outputHiZ",    outputHiZ,    it.wp);
        chk(it.tag, "inputIgnore",  inputIgnore,  it.wp);
        chk(it.tag, "batterySel",   batterySel,   it.bat);
        chk(it.tag, "memWriteEn",   memWriteEn,   it.wen);
        chk(it.tag, "tornFlag",     tornFlag,     it.torn);
      end
    end
  end

  // watchdog
  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // driver
  initial begin
    tick(3);
    chk("R1 in reset", "writeProtect", writeProtect, 1'b0);
    chk("R1 in reset", "batterySel",   batterySel,   1'b0);
    chk("R1 in reset", "tornFlag",     tornFlag,     1'b0);
    rstN = 1'b1;
    expectIn(1, 0, 0, 0, 0, "R1 after release");
    drain();

    // R2 pass-through write, then enable without write
    hostCeN = 1'b0; hostWeN = 1'b0;
    expectIn(1, 0, 0, 1, 0, "R2 write passes");
    drain();
    hostWeN = 1'b1;
    expectIn(1, 0, 0, 0, 0, "R2 read no strobe");
    drain();

    // R3 engage delay with a write in flight: R4 cut, R8 torn
    hostWeN = 1'b0; belowDeselect = 1'b1;
    expectIn(1, 0, 0, 1, 0, "R3 before engage");
    expectIn(ENG - 1, 0, 0, 1, 0, "R3 last unprotected edge");
    expectIn(ENG, 1, 0, 0, 1, "R4 R8 write cut and torn");
    drain();

    // R4 host write ignored while protected
    expectIn(1, 1, 0, 0, 1, "R4 strobes ignored");
    drain();
    hostCeN = 1'b1; hostWeN = 1'b1;

    // R5 battery on and off
    belowSwitch = 1'b1;
    expectIn(1, 1, 1, 0, 1, "R5 battery on");
    drain();
    belowSwitch = 1'b0;
    expectIn(1, 1, 0, 0, 1, "R5 battery off stays protected");
    drain();

    // R6 recovery interval
    belowDeselect = 1'b0;
    expectIn(REC, 1, 0, 0, 1, "R6 still held");
    expectIn(REC + 1, 0, 0, 0, 1, "R6 released");
    drain();

    // R3 short pulse has no effect
    belowDeselect = 1'b1;
    for (int i = 1; i <= ENG + 1; i++) expectIn(i, 0, 0, 0, 1, "R3 short pulse");
    tick(ENG - 1);
    belowDeselect = 1'b0;
    drain();

    // R8 clean entry clears the flag
    belowDeselect = 1'b1;
    expectIn(ENG, 1, 0, 0, 0, "R8 clean entry");
    drain();

    // R7 restart of recovery
    belowDeselect = 1'b0;
    expectIn(10, 1, 0, 0, 0, "R7 mid recovery");
    expectIn(REC + 11, 1, 0, 0, 0, "R7 restarted hold");
    expectIn(REC + 12, 0, 0, 0, 0, "R7 restarted release");
    tick(10);
    belowDeselect = 1'b1;
    tick(1);
    belowDeselect = 1'b0;
    drain();

    // R5 battery entered from recovery
    belowDeselect = 1'b1;
    tick(ENG);
    belowDeselect = 1'b0;
    tick(5);
    belowSwitch = 1'b1;
    expectIn(1, 1, 1, 0, 0, "R5 battery from recovery");
    drain();
    belowSwitch = 1'b0;
    expectIn(1, 1, 0, 0, 0, "R5 back to protect");
    expectIn(REC + 1, 1, 0, 0, 0, "R6 hold after battery");
    expectIn(REC + 2, 0, 0, 0, 0, "R6 release after battery");
    drain();

    // R1 reset during protection
    belowDeselect = 1'b1;
    tick(ENG + 1);
    rstN = 1'b0;
    belowDeselect = 1'b0;
    #1;
    chk("R1 reset mid protect", "writeProtect", writeProtect, 1'b0);
    chk("R1 reset mid protect", "outputHiZ",    outputHiZ,    1'b0);
    tick(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule